// File: doc/BRIEF.md
# Eight-Channel Timer Register Front End

This block is the bus-facing register decoder for a bank of eight timer channels. It takes 32-bit word accesses on a simple request interface. Each access goes to one of four registers in one channel (running count, reload value, first and second match values) or to one shared control word. The channel register storage lives in the channels themselves. The block only steers each access: a one-hot write or read strobe, a register index and the write data. It returns the read data of the selected channel on the same cycle.

The shared control word holds a 4-bit field per channel: enable, external clock select, overflow interrupt enable and pulse enable. The block decodes this word into per-channel outputs. When one write changes a field, the new settings reach the outputs in a fixed order. A cleared enable drops first. The remaining configuration follows one cycle later. A newly set enable rises one cycle after that. As a result, a channel never runs while its configuration is half updated. Pulse mode can be used only on the upper four channels. Setting it on a lower channel raises an error flag on that write.

Top module: `tmr_regfront`

## Requirements
- R1: After reset, and while reset is held, every enable, clock-select, interrupt-enable and pulse output is 0, and a read of the control word (offset 0x30) returns 0.
- R2: A valid write to offset 0x00–0x2C drives a one-hot write strobe for channel offset>>4 (channels 0–2). It drives register index (offset & 0xF)>>2 on the index output, with 0 = count, 1 = reload, 2 = match 1 and 3 = match 2, and passes the write data through unchanged.
- R3: Offsets 0x40–0x8C select channel (offset>>4)−1 (channels 3–7), with the same register index rule as R2.
- R4: A valid read of a channel register asserts that channel's one-hot read strobe and returns that channel's read data in the same cycle. A read of offset 0x30 returns the stored control word exactly as it was last written.
- R5: Channel n owns control bits [4n+3:4n]: bit 4n enables, bit 4n+1 selects the external clock, bit 4n+2 enables the overflow interrupt and bit 4n+3 enables pulse mode.
- R6: When a control write clears a channel's enable, the enable output falls on the write's clock edge. The clock-select and interrupt-enable outputs change only on the following edge.
- R7: When a control write sets a channel's enable, the configuration outputs change on the first edge after the write edge. The enable output rises on the edge after that.
- R8: Pulse mode is honoured only for channels 4–7. A control write that sets the pulse bit of channel 0–3 asserts the pulse-error output during that write. That channel's pulse output stays 0, but the bit is kept in the control word.
- R9: An access with any of addr[1:0] set, or with fewer than all four byte enables set, raises the error output. It produces no strobe, returns 0 and leaves the control word unchanged.
- R10: Accesses to unmapped offsets (0x34–0x3C and 0x90 or above) raise no error and no strobe. Reads of them return 0, and writes leave the control word unchanged.
- R11: A control write that keeps a running channel enabled but changes its configuration never drops that channel's enable output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset |
| be_i | input | 4 | Byte enables, little-endian |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| err_o | output | 1 | Misaligned or partial-width access |
| ch_wr_o | output | 8 | One-hot channel register write strobe |
| ch_rd_o | output | 8 | One-hot channel register read strobe |
| ch_reg_o | output | 2 | Register index within the channel |
| ch_wdata_o | output | 32 | Write data to the channels |
| ch_rdata_i | input | 256 | Read data from the channels, channel n at [32n+31:32n] |
| ch_en_o | output | 8 | Per-channel run enable |
| ch_ext_clk_o | output | 8 | Per-channel external clock select |
| ch_irq_en_o | output | 8 | Per-channel overflow interrupt enable |
| ch_pulse_o | output | 8 | Per-channel pulse mode, upper channels only |
| pulse_err_o | output | 1 | Pulse requested on a lower channel |

## Verification
Some properties are checked on every cycle. The strobes are at most one-hot. A rejected access produces no strobe, no data and no change to the control word. An enable edge never coincides with a change of that channel's configuration, which covers both orderings at once. The pulse error appears only on accepted writes. The bench scenarios show the rest: the exact address-to-channel mapping across both windows, the cycle on which each output moves, the lower-channel pulse masking, and configuration-only rewrites of a running channel.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_RELOAD = 2'd1,
    REG_MATCH1 = 2'd2,
    REG_MATCH2 = 2'd3
  } chreg_e;

  localparam int FIELD_W  = 4;
  localparam int FB_EN    = 0;
  localparam int FB_EXT   = 1;
  localparam int FB_IRQ   = 2;
  localparam int FB_PULSE = 3;
endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int N_CH   = 8,
  parameter int LOW_CH = 3,
  parameter int BE_W   = 4,
  localparam int CH_W  = $clog2(N_CH)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  output logic              ok_o,
  output logic              hit_ch_o,
  output logic              hit_ctrl_o,
  output logic [CH_W-1:0]   ch_idx_o,
  output chreg_e            reg_o
);
  localparam int SLOT_W = ADDR_W - 4;
  // control word sits directly after the low window, the high window one slot later
  localparam logic [ADDR_W-1:0] LOW_END = ADDR_W'(LOW_CH * 16);
  localparam logic [ADDR_W-1:0] HI_BASE = ADDR_W'((LOW_CH + 1) * 16);
  localparam logic [ADDR_W-1:0] HI_END  = ADDR_W'((N_CH + 1) * 16);

  logic [SLOT_W-1:0] slot;
  logic in_low, in_hi;

  assign slot       = addr_i[ADDR_W-1:4];
  assign in_low     = addr_i < LOW_END;
  assign in_hi      = (addr_i >= HI_BASE) && (addr_i < HI_END);
  assign ok_o       = (addr_i[1:0] == 2'b00) && (&be_i);
  assign hit_ch_o   = in_low || in_hi;
  assign hit_ctrl_o = (addr_i == LOW_END);
  assign ch_idx_o   = CH_W'(slot) - CH_W'(in_hi);
  assign reg_o      = chreg_e'(addr_i[3:2]);
endmodule

// File: rtl/tmr_ctrl_seq.sv
module tmr_ctrl_seq
  import tmr_pkg::*;
#(
  parameter int N_CH        = 8,
  parameter int PULSE_FIRST = 4,
  localparam int CW         = N_CH * FIELD_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [CW-1:0]   wdata_i,
  output logic [CW-1:0]   ctrl_o,
  output logic [N_CH-1:0] en_o,
  output logic [N_CH-1:0] ext_o,
  output logic [N_CH-1:0] irq_o,
  output logic [N_CH-1:0] pulse_o,
  output logic            perr_o
);
  typedef enum logic [1:0] {PH_IDLE, PH_CFG, PH_ENA} ph_e;

  function automatic logic [N_CH-1:0] pulse_mask_f();
    logic [N_CH-1:0] m;
    for (int i = 0; i < N_CH; i++) m[i] = (i >= PULSE_FIRST);
    return m;
  endfunction
  localparam logic [N_CH-1:0] PMASK = pulse_mask_f();

  ph_e             ph_q;
  logic [CW-1:0]   ctrl_q;
  logic [N_CH-1:0] en_q, ext_q, irq_q, pulse_q;
  logic [N_CH-1:0] c_en, c_ext, c_irq, c_pulse, w_en, w_pulse;

  always_comb begin
    for (int i = 0; i < N_CH; i++) begin
      c_en[i]    = ctrl_q[FIELD_W*i + FB_EN];
      c_ext[i]   = ctrl_q[FIELD_W*i + FB_EXT];
      c_irq[i]   = ctrl_q[FIELD_W*i + FB_IRQ];
      c_pulse[i] = ctrl_q[FIELD_W*i + FB_PULSE];
      w_en[i]    = wdata_i[FIELD_W*i + FB_EN];
      w_pulse[i] = wdata_i[FIELD_W*i + FB_PULSE];
    end
  end

  // write edge: disables only; next edge: configuration; edge after: enables
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      ctrl_q  <= '0;
      en_q    <= '0;
      ext_q   <= '0;
      irq_q   <= '0;
      pulse_q <= '0;
    end else if (wr_i) begin
      ctrl_q <= wdata_i;
      en_q   <= en_q & w_en;
      ph_q   <= PH_CFG;
    end else begin
      case (ph_q)
        PH_CFG: begin
          ext_q   <= c_ext;
          irq_q   <= c_irq;
          pulse_q <= c_pulse & PMASK;
          ph_q    <= PH_ENA;
        end
        PH_ENA: begin
          en_q <= c_en;
          ph_q <= PH_IDLE;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign ctrl_o  = ctrl_q;
  assign en_o    = en_q;
  assign ext_o   = ext_q;
  assign irq_o   = irq_q;
  assign pulse_o = pulse_q;
  assign perr_o  = wr_i && |(w_pulse & ~PMASK);
endmodule

// File: rtl/tmr_regfront.sv
module tmr_regfront
  import tmr_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int N_CH        = 8,
  parameter int LOW_CH      = 3,
  parameter int PULSE_FIRST = 4,
  localparam int BE_W       = DATA_W / 8,
  localparam int CH_W       = $clog2(N_CH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [BE_W-1:0]        be_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   err_o,
  output logic [N_CH-1:0]        ch_wr_o,
  output logic [N_CH-1:0]        ch_rd_o,
  output logic [1:0]             ch_reg_o,
  output logic [DATA_W-1:0]      ch_wdata_o,
  input  logic [N_CH*DATA_W-1:0] ch_rdata_i,
  output logic [N_CH-1:0]        ch_en_o,
  output logic [N_CH-1:0]        ch_ext_clk_o,
  output logic [N_CH-1:0]        ch_irq_en_o,
  output logic [N_CH-1:0]        ch_pulse_o,
  output logic                   pulse_err_o
);
  localparam int CW = N_CH * FIELD_W;

  logic            ok, hit_ch, hit_ctrl;
  logic [CH_W-1:0] ch_idx;
  chreg_e          reg_idx;
  logic            acc, ctrl_wr;
  logic [CW-1:0]   ctrl_w;

  tmr_addr_dec #(
    .ADDR_W(ADDR_W), .N_CH(N_CH), .LOW_CH(LOW_CH), .BE_W(BE_W)
  ) i_dec (
    .addr_i    (addr_i),
    .be_i      (be_i),
    .ok_o      (ok),
    .hit_ch_o  (hit_ch),
    .hit_ctrl_o(hit_ctrl),
    .ch_idx_o  (ch_idx),
    .reg_o     (reg_idx)
  );

  assign acc     = req_i && ok;
  assign ctrl_wr = acc && we_i && hit_ctrl;

  tmr_ctrl_seq #(
    .N_CH(N_CH), .PULSE_FIRST(PULSE_FIRST)
  ) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (ctrl_wr),
    .wdata_i(wdata_i[CW-1:0]),
    .ctrl_o (ctrl_w),
    .en_o   (ch_en_o),
    .ext_o  (ch_ext_clk_o),
    .irq_o  (ch_irq_en_o),
    .pulse_o(ch_pulse_o),
    .perr_o (pulse_err_o)
  );

  assign err_o      = req_i && !ok;
  assign ch_wr_o    = (acc && we_i && hit_ch)  ? (N_CH'(1) << ch_idx) : '0;
  assign ch_rd_o    = (acc && !we_i && hit_ch) ? (N_CH'(1) << ch_idx) : '0;
  assign ch_reg_o   = reg_idx;
  assign ch_wdata_o = wdata_i;

  always_comb begin
    rdata_o = '0;
    if (acc && !we_i) begin
      if (hit_ch)        rdata_o = ch_rdata_i[int'(ch_idx)*DATA_W +: DATA_W];
      else if (hit_ctrl) rdata_o = DATA_W'(ctrl_w);
    end
  end
endmodule

// File: rtl/tmr_regfront_chk.sv
module tmr_regfront_chk #(
  parameter int N_CH   = 8,
  parameter int DATA_W = 32,
  parameter int CW     = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic              err_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [N_CH-1:0]   ch_wr_o,
  input logic [N_CH-1:0]   ch_rd_o,
  input logic [N_CH-1:0]   ch_en_o,
  input logic [N_CH-1:0]   ch_ext_clk_o,
  input logic [N_CH-1:0]   ch_irq_en_o,
  input logic              pulse_err_o,
  input logic [CW-1:0]     ctrl_q
);
  p_wr_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_wr_o));
  p_rd_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_rd_o));
  p_err_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ch_wr_o == '0 && ch_rd_o == '0 && rdata_o == '0));
  p_err_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && err_o) |=> $stable(ctrl_q));
  p_perr_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_err_o |-> (req_i && we_i && !err_o));

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    p_off_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ch_en_o[g]) |-> ($stable(ch_ext_clk_o[g]) && $stable(ch_irq_en_o[g])));
    p_on_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ch_en_o[g]) |-> ($stable(ch_ext_clk_o[g]) && $stable(ch_irq_en_o[g])));
  end
endmodule

bind tmr_regfront tmr_regfront_chk #(
  .N_CH(N_CH), .DATA_W(DATA_W), .CW(N_CH * tmr_pkg::FIELD_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .err_o       (err_o),
  .rdata_o     (rdata_o),
  .ch_wr_o     (ch_wr_o),
  .ch_rd_o     (ch_rd_o),
  .ch_en_o     (ch_en_o),
  .ch_ext_clk_o(ch_ext_clk_o),
  .ch_irq_en_o (ch_irq_en_o),
  .pulse_err_o (pulse_err_o),
  .ctrl_q      (ctrl_w)
);

// File: tb/test_tmr_regfront.sv
module test_tmr_regfront;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err, perr;
  logic [7:0]  ch_wr, ch_rd, en, ext, irq, pulse;
  logic [1:0]  ch_reg;
  logic [31:0] ch_wdata;
  logic [255:0] ch_rdata;

  int total = 0, bad = 0;
  bit done = 0;

  logic [7:0]  cap_wr, cap_rd;
  logic [1:0]  cap_reg;
  logic        cap_err, cap_perr;
  logic [31:0] cap_rdata, cap_wdata;

  always #10 clk = ~clk;

  tmr_regfront i_tmr_regfront (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .ch_wr_o(ch_wr), .ch_rd_o(ch_rd), .ch_reg_o(ch_reg), .ch_wdata_o(ch_wdata),
    .ch_rdata_i(ch_rdata), .ch_en_o(en), .ch_ext_clk_o(ext),
    .ch_irq_en_o(irq), .ch_pulse_o(pulse), .pulse_err_o(perr)
  );

  // channel stubs: four plain registers each
  logic [31:0] stub_q [8][4];
  always_ff @(posedge clk) begin
    for (int i = 0; i < 8; i++)
      if (ch_wr[i]) stub_q[i][ch_reg] <= ch_wdata;
  end
  for (genvar g = 0; g < 8; g++) begin : g_stub
    assign ch_rdata[g*32 +: 32] = stub_q[g][ch_reg];
  end

  // {offset, channel, register}
  localparam logic [16:0] VEC [10] = '{
    {12'h000, 3'd0, 2'd0}, {12'h014, 3'd1, 2'd1}, {12'h028, 3'd2, 2'd2},
    {12'h02C, 3'd2, 2'd3}, {12'h040, 3'd3, 2'd0}, {12'h054, 3'd4, 2'd1},
    {12'h068, 3'd5, 2'd2}, {12'h07C, 3'd6, 2'd3}, {12'h080, 3'd7, 2'd0},
    {12'h08C, 3'd7, 2'd3}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(logic w, logic [11:0] a, logic [31:0] d, logic [3:0] b);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; be = b;
    #2;
    cap_wr = ch_wr; cap_rd = ch_rd; cap_reg = ch_reg; cap_err = err;
    cap_perr = perr; cap_rdata = rdata; cap_wdata = ch_wdata;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] saved14;
    repeat (3) @(negedge clk);
    #2;
    check("R1 en in reset", {24'h0, en}, 32'h0);
    rst_ni = 1'b1;
    access(1'b0, 12'h030, 0, 4'hF);
    check("R1 ctrl read after reset", cap_rdata, 32'h0);
    check("R1 outputs after reset", {en, ext, irq, pulse}, 32'h0);

    for (int k = 0; k < 10; k++) begin
      logic [11:0] a; logic [2:0] c; logic [1:0] r; logic [31:0] d;
      {a, c, r} = VEC[k];
      d = 32'hA500_0000 | {20'h0, a};
      access(1'b1, a, d, 4'hF);
      check(a < 12'h040 ? "R2 wr strobe" : "R3 wr strobe", {24'h0, cap_wr}, 32'h1 << c);
      check("R2 reg index", {30'h0, cap_reg}, {30'h0, r});
      check("R2 wdata pass", cap_wdata, d);
      access(1'b0, a, 0, 4'hF);
      check("R4 rd strobe", {24'h0, cap_rd}, 32'h1 << c);
      check("R4 read data", cap_rdata, d);
    end

    // R7: enable with config
    access(1'b1, 12'h030, 32'h0000_0007, 4'hF);
    check("R7 T0 en", {24'h0, en}, 32'h00);
    check("R7 T0 ext", {24'h0, ext}, 32'h00);
    step();
    check("R7 T1 ext", {24'h0, ext}, 32'h01);
    check("R7 T1 irq", {24'h0, irq}, 32'h01);
    check("R7 T1 en", {24'h0, en}, 32'h00);
    step();
    check("R7 T2 en", {24'h0, en}, 32'h01);
    access(1'b0, 12'h030, 0, 4'hF);
    check("R5 ctrl readback", cap_rdata, 32'h0000_0007);

    // R6 disable first, R5 field positions, R8 low-channel pulse
    access(1'b1, 12'h030, 32'h6000_0A06, 4'hF);
    check("R8 perr ch2", {31'h0, cap_perr}, 32'h1);
    check("R6 T0 en", {24'h0, en}, 32'h00);
    check("R6 T0 ext held", {24'h0, ext}, 32'h01);
    check("R6 T0 irq held", {24'h0, irq}, 32'h01);
    step();
    check("R5 ext fields", {24'h0, ext}, 32'h85);
    check("R5 irq fields", {24'h0, irq}, 32'h81);
    check("R8 ch2 pulse masked", {24'h0, pulse}, 32'h00);
    step();
    check("R6 en stays off", {24'h0, en}, 32'h00);

    // R11 config change on running channel
    access(1'b1, 12'h030, 32'h0000_0003, 4'hF);
    step(); step();
    check("R11 setup en", {24'h0, en}, 32'h01);
    access(1'b1, 12'h030, 32'h0000_0001, 4'hF);
    check("R11 T0 en", {24'h0, en}, 32'h01);
    step();
    check("R11 T1 en", {24'h0, en}, 32'h01);
    check("R11 T1 ext", {24'h0, ext}, 32'h00);
    step();
    check("R11 T2 en", {24'h0, en}, 32'h01);

    // R8 upper channels honoured
    access(1'b1, 12'h030, 32'h8008_8000, 4'hF);
    check("R8 perr ch3", {31'h0, cap_perr}, 32'h1);
    step(); step();
    check("R8 pulse ch4 ch7", {24'h0, pulse}, 32'h90);
    access(1'b1, 12'h030, 32'h8008_0000, 4'hF);
    check("R8 no perr upper", {31'h0, cap_perr}, 32'h0);
    access(1'b0, 12'h030, 0, 4'hF);
    check("R8 ctrl keeps bits", cap_rdata, 32'h8008_0000);

    // R9 misaligned / partial
    access(1'b0, 12'h014, 0, 4'hF);
    saved14 = cap_rdata;
    access(1'b1, 12'h032, 32'hFFFF_FFFF, 4'hF);
    check("R9 misaligned err", {31'h0, cap_err}, 32'h1);
    check("R9 misaligned no strobe", {24'h0, cap_wr}, 32'h0);
    access(1'b1, 12'h014, 32'h1234_5678, 4'h3);
    check("R9 partial err", {31'h0, cap_err}, 32'h1);
    check("R9 partial no strobe", {24'h0, cap_wr}, 32'h0);
    access(1'b0, 12'h015, 0, 4'hF);
    check("R9 misaligned read zero", cap_rdata, 32'h0);
    access(1'b0, 12'h014, 0, 4'hF);
    check("R9 channel reg untouched", cap_rdata, saved14);
    access(1'b0, 12'h030, 0, 4'hF);
    check("R9 ctrl untouched", cap_rdata, 32'h8008_0000);

    // R10 unmapped
    access(1'b1, 12'h034, 32'hFFFF_FFFF, 4'hF);
    check("R10 no err", {31'h0, cap_err}, 32'h0);
    check("R10 no strobe", {24'h0, cap_wr}, 32'h0);
    access(1'b1, 12'h090, 32'hFFFF_FFFF, 4'hF);
    check("R10 no strobe high", {24'h0, cap_wr}, 32'h0);
    access(1'b1, 12'h03C, 32'hFFFF_FFFF, 4'hF);
    access(1'b0, 12'h038, 0, 4'hF);
    check("R10 read zero", cap_rdata, 32'h0);
    check("R10 no rd strobe", {24'h0, cap_rd}, 32'h0);
    access(1'b0, 12'h030, 0, 4'hF);
    check("R10 ctrl unchanged", cap_rdata, 32'h8008_0000);

    // R1 mid-run reset
    access(1'b1, 12'h030, 32'hFFFF_FFFF, 4'hF);
    step(); step();
    check("R1 pre-reset en", {24'h0, en}, 32'hFF);
    @(negedge clk);
    rst_ni = 1'b0;
    #2;
    check("R1 reset clears", {en, ext, irq, pulse}, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    access(1'b0, 12'h030, 0, 4'hF);
    check("R1 ctrl cleared", cap_rdata, 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule